// File: doc/BRIEF.md
# Instruction Fetch Address Translation Checker

This block sits between instruction fetch and an external translation lookaside buffer. For each fetch request it takes the virtual address and the processor state: the hypervisor and reset/error-state flags, the trap level, the privilege and 32-bit address-mask flags, the instruction-MMU enable, the partition and the primary context. It either produces a physical address or reports one trap code. The TLB storage lives outside. The block drives a lookup request on a same-cycle port and combines the entry that comes back.

The checks run in a fixed order and the first one that applies decides the result. The order is: translation bypass, alignment, the 32-bit address mask, the unimplemented-VA hole, the choice between a real and a virtual lookup, the miss, and the privilege check. Some faults update a fault status word, which carries an overflow bit and the fault cause. Every miss updates a tag-access word, which holds the page address and context that a refill handler needs. Results are registered and appear one clock after the request.

Top module: `ifetch_xlate`

## Requirements
- R1: When the trap level is nonzero, the nucleus context (0), the nucleus ASI (ASI_NUC, 0x04 by default) and context type 2 are used. Otherwise the primary context, the primary ASI (ASI_PRI, 0x80 by default) and context type 0 are used.
- R2: If `hyperPriv` or `redState` is set, no lookup is issued (`tlbReqValid` low). The result has trap code 0 and PA = VA[PA_W-1:0]. The fault status and tag-access words are left unchanged.
- R3: If the bypass does not apply and VA[2:0] is nonzero, the trap code is 1 (misaligned) and the fault type is 1.
- R4: With `addrMask` set, the effective VA is VA[31:0] zero-extended and the hole check is skipped. A virtual lookup presents the effective VA.
- R5: With `addrMask` clear, a VA in [HOLE_LO, HOLE_HI] gives trap code 2 (access exception) with fault type 2. Both bounds are inclusive.
- R6: With `mmuEnable` clear, the lookup is real (`tlbReqReal`=1) with context 0 and presents the raw VA. Otherwise the lookup is virtual and uses the context chosen by R1.
- R7: On a miss, the trap code is 3 for a real lookup and 4 for a virtual lookup. The tag-access word becomes the effective VA with its low PAGE_BITS bits cleared, ORed with the lookup context. The fault status word is not changed.
- R8: On a hit with `privMode` clear and a privileged page (`tlbPriv`), the trap code is 2 and the fault type is 3.
- R9: On a hit without a fault, PA = (tlbPa & ~tlbPageMask) | (VA & tlbPageMask), with trap code 0.
- R10: The fault types 1, 2 and 3 write the fault status word as follows: bit0=1, bit1=the previous bit0, bit2 (write)=0, bits5:4=context type, bit6 (side effect)=0, bits10:7=fault type, bits 16 and up=ASI, all other bits 0.
- R11: After reset, `rspValid`, `faultStatus` and `tagAccess` are 0. `rspValid` is high exactly in the cycle after a cycle with `reqValid` high. `rspPa` is 0 whenever a trap is reported.
- R12: When several conditions hold at once, the earlier check in the order bypass, misalignment, hole, miss, privilege decides the trap code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Fetch translation request |
| reqVa | input | VA_W | Fetch virtual address |
| hyperPriv | input | 1 | Hypervisor-privileged state |
| redState | input | 1 | Reset/error state |
| trapLevel | input | TL_W | Current trap level |
| privMode | input | 1 | Privileged mode |
| addrMask | input | 1 | 32-bit address masking enable |
| mmuEnable | input | 1 | Instruction MMU enable |
| partId | input | PID_W | Partition identifier |
| primaryCtx | input | CTX_W | Primary context |
| tlbReqValid | output | 1 | Lookup request to the TLB |
| tlbReqVa | output | VA_W | Lookup address |
| tlbReqPid | output | PID_W | Lookup partition |
| tlbReqCtx | output | CTX_W | Lookup context |
| tlbReqReal | output | 1 | Real (not virtual) lookup |
| tlbHit | input | 1 | Same-cycle lookup hit |
| tlbPriv | input | 1 | Hit entry is privileged-only |
| tlbPa | input | PA_W | Hit entry physical address |
| tlbPageMask | input | PA_W | Hit entry in-page offset mask |
| rspValid | output | 1 | Result valid |
| rspTrap | output | 3 | Trap code (0 none, 1 misaligned, 2 access, 3 real miss, 4 fast miss) |
| rspPa | output | PA_W | Translated physical address |
| faultStatus | output | ASI_W+16 | Fault status word |
| tagAccess | output | VA_W | Tag-access word for miss handling |

## Verification
The bench builds the block with its default parameters: a 64-bit VA, a 40-bit PA, 13-bit contexts, 8 KiB base pages and a hole from 0x0000_8000_0000_0000 to 0xFFFF_7FFF_FFFF_FFFF. With a 64-bit VA, both hole edges and addresses that only the 32-bit mask rescues from the hole can be reached. With the PA narrower than the VA, truncation in bypass shows in the result. With contexts as wide as the page offset, a full-width context lands in the tag-access word next to the page number, and the bench checks it there.

// File: rtl/ifx_pkg.sv
package ifx_pkg;

  typedef enum logic [2:0] {
    TRAP_NONE      = 3'd0,
    TRAP_MISALIGN  = 3'd1,
    TRAP_ACCESS    = 3'd2,
    TRAP_REAL_MISS = 3'd3,
    TRAP_FAST_MISS = 3'd4
  } trap_e;

  typedef enum logic [3:0] {
    FT_NONE     = 4'd0,
    FT_OTHER    = 4'd1,
    FT_VA_RANGE = 4'd2,
    FT_PRIV     = 4'd3
  } fault_e;

  typedef enum logic [1:0] {
    CT_PRIMARY   = 2'd0,
    CT_SECONDARY = 2'd1,
    CT_NUCLEUS   = 2'd2
  } ctx_e;

  typedef enum logic [1:0] {
    PA_NONE   = 2'd0,
    PA_BYPASS = 2'd1,
    PA_TLB    = 2'd2
  } pasel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   rspLoad;
    trap_e  trap;
    pasel_e paSel;
    logic   statusWr;
    fault_e faultType;
    logic   tagWr;
    logic   tlbReq;
    logic   realLookup;
    logic   useNucleus;
  } strobe_t;

endpackage

// File: rtl/ifx_ctrl.sv
module ifx_ctrl
  import ifx_pkg::*;
(
  input  logic    reqValid,
  input  logic    hyperPriv,
  input  logic    redState,
  input  logic    tlNonZero,
  input  logic    privMode,
  input  logic    addrMask,
  input  logic    mmuEnable,
  input  logic    vaMisaligned,
  input  logic    vaInHole,
  input  logic    tlbHit,
  input  logic    tlbPriv,
  output strobe_t stb
);

  // priority walk: bypass, alignment, hole, lookup, miss, privilege
  always_comb begin
    stb            = '0;
    stb.rspLoad    = reqValid;
    stb.useNucleus = tlNonZero;
    stb.realLookup = !mmuEnable;
    stb.trap       = TRAP_NONE;
    stb.paSel      = PA_NONE;
    stb.faultType  = FT_NONE;
    if (hyperPriv || redState) begin
      stb.paSel = PA_BYPASS;
    end else if (vaMisaligned) begin
      stb.trap      = TRAP_MISALIGN;
      stb.faultType = FT_OTHER;
    end else if (!addrMask && vaInHole) begin
      stb.trap      = TRAP_ACCESS;
      stb.faultType = FT_VA_RANGE;
    end else begin
      stb.tlbReq = reqValid;
      if (!tlbHit) begin
        stb.trap  = mmuEnable ? TRAP_FAST_MISS : TRAP_REAL_MISS;
        stb.tagWr = reqValid;
      end else if (!privMode && tlbPriv) begin
        stb.trap      = TRAP_ACCESS;
        stb.faultType = FT_PRIV;
      end else begin
        stb.paSel = PA_TLB;
      end
    end
    stb.statusWr = reqValid && (stb.faultType != FT_NONE);
  end

endmodule

// File: rtl/ifx_dpath.sv
module ifx_dpath
  import ifx_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int PA_W      = 40,
  parameter int CTX_W     = 13,
  parameter int PID_W     = 3,
  parameter int ASI_W     = 8,
  parameter int PAGE_BITS = 13,
  parameter logic [VA_W-1:0]  HOLE_LO = 64'h0000_8000_0000_0000,
  parameter logic [VA_W-1:0]  HOLE_HI = 64'hFFFF_7FFF_FFFF_FFFF,
  parameter logic [ASI_W-1:0] ASI_NUC = 8'h04,
  parameter logic [ASI_W-1:0] ASI_PRI = 8'h80,
  localparam int SW_W = ASI_W + 16,
  localparam int HI_W = VA_W - 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          stb,
  input  logic [VA_W-1:0]  reqVa,
  input  logic             addrMask,
  input  logic [PID_W-1:0] partId,
  input  logic [CTX_W-1:0] primaryCtx,
  input  logic [PA_W-1:0]  tlbPa,
  input  logic [PA_W-1:0]  tlbPageMask,
  output logic             vaMisaligned,
  output logic             vaInHole,
  output logic [VA_W-1:0]  tlbReqVa,
  output logic [PID_W-1:0] tlbReqPid,
  output logic [CTX_W-1:0] tlbReqCtx,
  output logic             tlbReqReal,
  output logic             rspValid,
  output logic [2:0]       rspTrap,
  output logic [PA_W-1:0]  rspPa,
  output logic [SW_W-1:0]  faultStatus,
  output logic [VA_W-1:0]  tagAccess
);

  logic [VA_W-1:0]  effVa;
  logic [CTX_W-1:0] selCtx;
  logic [CTX_W-1:0] lookupCtx;
  logic [ASI_W-1:0] asiSel;
  ctx_e             ctxType;
  logic [PA_W-1:0]  paNext;
  logic [VA_W-1:0]  tagNext;
  logic [SW_W-1:0]  statusNext;
  trap_e            trapQ;

  assign effVa        = addrMask ? {{HI_W{1'b0}}, reqVa[31:0]} : reqVa;
  assign vaMisaligned = |reqVa[2:0];
  assign vaInHole     = (reqVa >= HOLE_LO) && (reqVa <= HOLE_HI);

  assign selCtx    = stb.useNucleus ? '0 : primaryCtx;
  assign lookupCtx = stb.realLookup ? '0 : selCtx;
  assign asiSel    = stb.useNucleus ? ASI_NUC : ASI_PRI;
  assign ctxType   = stb.useNucleus ? CT_NUCLEUS : CT_PRIMARY;

  assign tlbReqVa   = stb.realLookup ? reqVa : effVa;
  assign tlbReqPid  = partId;
  assign tlbReqCtx  = lookupCtx;
  assign tlbReqReal = stb.realLookup;

  always_comb begin
    case (stb.paSel)
      PA_BYPASS: paNext = reqVa[PA_W-1:0];
      PA_TLB:    paNext = (tlbPa & ~tlbPageMask) | (reqVa[PA_W-1:0] & tlbPageMask);
      default:   paNext = '0;
    endcase
  end

  assign tagNext = {effVa[VA_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}} | VA_W'(lookupCtx);

  assign statusNext = {asiSel, 5'b0, stb.faultType, 1'b0, ctxType, 2'b00,
                       faultStatus[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rspValid    <= 1'b0;
      trapQ       <= TRAP_NONE;
      rspPa       <= '0;
      faultStatus <= '0;
      tagAccess   <= '0;
    end else begin
      rspValid <= stb.rspLoad;
      if (stb.rspLoad) begin
        trapQ <= stb.trap;
        rspPa <= paNext;
      end
      if (stb.statusWr) faultStatus <= statusNext;
      if (stb.tagWr)    tagAccess   <= tagNext;
    end
  end

  assign rspTrap = trapQ;

endmodule

// File: rtl/ifetch_xlate.sv
module ifetch_xlate
  import ifx_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int PA_W      = 40,
  parameter int CTX_W     = 13,
  parameter int PID_W     = 3,
  parameter int TL_W      = 3,
  parameter int ASI_W     = 8,
  parameter int PAGE_BITS = 13,
  parameter logic [VA_W-1:0]  HOLE_LO = 64'h0000_8000_0000_0000,
  parameter logic [VA_W-1:0]  HOLE_HI = 64'hFFFF_7FFF_FFFF_FFFF,
  parameter logic [ASI_W-1:0] ASI_NUC = 8'h04,
  parameter logic [ASI_W-1:0] ASI_PRI = 8'h80
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reqValid,
  input  logic [VA_W-1:0]    reqVa,
  input  logic               hyperPriv,
  input  logic               redState,
  input  logic [TL_W-1:0]    trapLevel,
  input  logic               privMode,
  input  logic               addrMask,
  input  logic               mmuEnable,
  input  logic [PID_W-1:0]   partId,
  input  logic [CTX_W-1:0]   primaryCtx,
  output logic               tlbReqValid,
  output logic [VA_W-1:0]    tlbReqVa,
  output logic [PID_W-1:0]   tlbReqPid,
  output logic [CTX_W-1:0]   tlbReqCtx,
  output logic               tlbReqReal,
  input  logic               tlbHit,
  input  logic               tlbPriv,
  input  logic [PA_W-1:0]    tlbPa,
  input  logic [PA_W-1:0]    tlbPageMask,
  output logic               rspValid,
  output logic [2:0]         rspTrap,
  output logic [PA_W-1:0]    rspPa,
  output logic [ASI_W+15:0]  faultStatus,
  output logic [VA_W-1:0]    tagAccess
);

  strobe_t stb;
  logic    vaMisaligned;
  logic    vaInHole;

  ifx_ctrl u_ctrl (
    .reqValid     (reqValid),
    .hyperPriv    (hyperPriv),
    .redState     (redState),
    .tlNonZero    (|trapLevel),
    .privMode     (privMode),
    .addrMask     (addrMask),
    .mmuEnable    (mmuEnable),
    .vaMisaligned (vaMisaligned),
    .vaInHole     (vaInHole),
    .tlbHit       (tlbHit),
    .tlbPriv      (tlbPriv),
    .stb          (stb)
  );

  ifx_dpath #(
    .VA_W(VA_W), .PA_W(PA_W), .CTX_W(CTX_W), .PID_W(PID_W), .ASI_W(ASI_W),
    .PAGE_BITS(PAGE_BITS), .HOLE_LO(HOLE_LO), .HOLE_HI(HOLE_HI),
    .ASI_NUC(ASI_NUC), .ASI_PRI(ASI_PRI)
  ) u_dpath (
    .clk          (clk),
    .rst_n        (rst_n),
    .stb          (stb),
    .reqVa        (reqVa),
    .addrMask     (addrMask),
    .partId       (partId),
    .primaryCtx   (primaryCtx),
    .tlbPa        (tlbPa),
    .tlbPageMask  (tlbPageMask),
    .vaMisaligned (vaMisaligned),
    .vaInHole     (vaInHole),
    .tlbReqVa     (tlbReqVa),
    .tlbReqPid    (tlbReqPid),
    .tlbReqCtx    (tlbReqCtx),
    .tlbReqReal   (tlbReqReal),
    .rspValid     (rspValid),
    .rspTrap      (rspTrap),
    .rspPa        (rspPa),
    .faultStatus  (faultStatus),
    .tagAccess    (tagAccess)
  );

  assign tlbReqValid = stb.tlbReq;

endmodule

// File: rtl/ifx_xlate_chk.sv
module ifx_xlate_chk #(
  parameter int VA_W  = 64,
  parameter int PA_W  = 40,
  parameter int CTX_W = 13,
  parameter int SW_W  = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reqValid,
  input logic [VA_W-1:0]  reqVa,
  input logic             hyperPriv,
  input logic             redState,
  input logic             mmuEnable,
  input logic             tlbReqValid,
  input logic [CTX_W-1:0] tlbReqCtx,
  input logic             tlbReqReal,
  input logic             tlbHit,
  input logic             rspValid,
  input logic [2:0]       rspTrap,
  input logic [PA_W-1:0]  rspPa,
  input logic [SW_W-1:0]  faultStatus
);

  // R11
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> rspValid);

  // R11
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !rspValid);

  // R2
  bypass_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && (hyperPriv || redState)) |=>
      (rspTrap == 3'd0 && rspPa == $past(reqVa[PA_W-1:0])));

  // R2
  bypass_no_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hyperPriv || redState) |-> !tlbReqValid);

  // R3
  misalign_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !hyperPriv && !redState && (reqVa[2:0] != 3'd0)) |=>
      (rspTrap == 3'd1));

  // R6
  real_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tlbReqValid && !mmuEnable) |-> (tlbReqReal && tlbReqCtx == '0));

  // R7
  miss_keeps_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tlbReqValid && !tlbHit) |=> $stable(faultStatus));

  // R10
  status_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && rspTrap == 3'd1) |-> faultStatus[0]);

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !hyperPriv && !redState && (reqVa[2:0] != 3'd0) && faultStatus[0])
      |=> faultStatus[1]);

endmodule

bind ifetch_xlate ifx_xlate_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .CTX_W(CTX_W), .SW_W(ASI_W + 16)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqVa(reqVa),
  .hyperPriv(hyperPriv), .redState(redState), .mmuEnable(mmuEnable),
  .tlbReqValid(tlbReqValid), .tlbReqCtx(tlbReqCtx), .tlbReqReal(tlbReqReal),
  .tlbHit(tlbHit), .rspValid(rspValid), .rspTrap(rspTrap), .rspPa(rspPa),
  .faultStatus(faultStatus)
);

// File: tb/test_ifetch_xlate.sv
module test_ifetch_xlate;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reqValid;
  logic [63:0] reqVa;
  logic        hyperPriv, redState;
  logic [2:0]  trapLevel;
  logic        privMode, addrMask, mmuEnable;
  logic [2:0]  partId;
  logic [12:0] primaryCtx;
  logic        tlbReqValid;
  logic [63:0] tlbReqVa;
  logic [2:0]  tlbReqPid;
  logic [12:0] tlbReqCtx;
  logic        tlbReqReal;
  logic        tlbHit, tlbPriv;
  logic [39:0] tlbPa, tlbPageMask;
  logic        rspValid;
  logic [2:0]  rspTrap;
  logic [39:0] rspPa;
  logic [23:0] faultStatus;
  logic [63:0] tagAccess;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ifetch_xlate i_ifetch_xlate (.*);

  typedef struct packed {
    logic        hp;
    logic        red;
    logic [2:0]  tl;
    logic        priv;
    logic        am;
    logic        mmuEn;
    logic [63:0] va;
    logic        hit;
    logic        tpriv;
    logic [39:0] tpa;
    logic [39:0] tmask;
    logic [2:0]  expTrap;
    logic [39:0] expPa;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VECS [NVEC] = '{
    // R2 hypervisor bypass, misaligned VA ignored, PA truncated
    '{1'b1,1'b0,3'd0,1'b1,1'b0,1'b1,64'hFFFF_FFFF_1234_5677,1'b0,1'b0,40'h0,40'h0,3'd0,40'hFF_1234_5677,8'd2},
    // R2 reset/error-state bypass of a hole address
    '{1'b0,1'b1,3'd0,1'b1,1'b0,1'b1,64'h0000_8000_0000_0000,1'b0,1'b0,40'h0,40'h0,3'd0,40'h0,8'd2},
    // R3 misaligned
    '{1'b0,1'b0,3'd0,1'b1,1'b0,1'b1,64'h1004,1'b1,1'b0,40'h0,40'h0,3'd1,40'h0,8'd3},
    // R12 misaligned wins over hole
    '{1'b0,1'b0,3'd1,1'b1,1'b0,1'b1,64'h0000_8000_0000_0002,1'b1,1'b0,40'h0,40'h0,3'd1,40'h0,8'd12},
    // R5 hole lower bound
    '{1'b0,1'b0,3'd0,1'b1,1'b0,1'b1,64'h0000_8000_0000_0000,1'b1,1'b0,40'h0,40'h0,3'd2,40'h0,8'd5},
    // R5 hole upper edge
    '{1'b0,1'b0,3'd0,1'b1,1'b0,1'b1,64'hFFFF_7FFF_FFFF_FFF8,1'b1,1'b0,40'h0,40'h0,3'd2,40'h0,8'd5},
    // R5 just below hole translates
    '{1'b0,1'b0,3'd0,1'b1,1'b0,1'b1,64'h0000_7FFF_FFFF_FFF8,1'b1,1'b0,40'h12_3456_0000,40'h1FFF,3'd0,40'h12_3456_1FF8,8'd5},
    // R5 just above hole translates
    '{1'b0,1'b0,3'd0,1'b1,1'b0,1'b1,64'hFFFF_8000_0000_0000,1'b1,1'b0,40'hAB_CDEF_2000,40'h1FFF,3'd0,40'hAB_CDEF_2000,8'd5},
    // R4 address mask skips hole
    '{1'b0,1'b0,3'd0,1'b1,1'b1,1'b1,64'h0000_8000_0000_1008,1'b1,1'b0,40'h00_5555_4000,40'h1FFF,3'd0,40'h00_5555_5008,8'd4},
    // R7 virtual miss
    '{1'b0,1'b0,3'd0,1'b1,1'b0,1'b1,64'h2000,1'b0,1'b0,40'h0,40'h0,3'd4,40'h0,8'd7},
    // R7 real miss
    '{1'b0,1'b0,3'd0,1'b1,1'b0,1'b0,64'h2000,1'b0,1'b0,40'h0,40'h0,3'd3,40'h0,8'd7},
    // R8 privilege violation
    '{1'b0,1'b0,3'd0,1'b0,1'b0,1'b1,64'h2000,1'b1,1'b1,40'h33_0000_0000,40'h1FFF,3'd2,40'h0,8'd8},
    // R9 privileged page in privileged mode, 4 MiB page
    '{1'b0,1'b0,3'd0,1'b1,1'b0,1'b1,64'h1234_5678,1'b1,1'b1,40'h01_0000_0000,40'h3F_FFFF,3'd0,40'h01_0034_5678,8'd9},
    // R12 miss wins over privilege
    '{1'b0,1'b0,3'd0,1'b0,1'b0,1'b1,64'h2000,1'b0,1'b1,40'h0,40'h0,3'd4,40'h0,8'd12},
    // R12 hole wins over miss
    '{1'b0,1'b0,3'd0,1'b1,1'b0,1'b1,64'h0000_9000_0000_0000,1'b0,1'b0,40'h0,40'h0,3'd2,40'h0,8'd12}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    reqValid = 0; reqVa = '0; hyperPriv = 0; redState = 0; trapLevel = 0;
    privMode = 1; addrMask = 0; mmuEnable = 1; partId = 3'd3; primaryCtx = 13'h0AB;
    tlbHit = 0; tlbPriv = 0; tlbPa = '0; tlbPageMask = 40'h1FFF;
  endtask

  task automatic doReset();
    @(negedge clk);
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(rspValid == 0, "R11", "reset rspValid", 64'(rspValid), 0);
    chk(faultStatus == 0, "R11", "reset faultStatus", 64'(faultStatus), 0);
    chk(tagAccess == 0, "R11", "reset tagAccess", tagAccess, 0);
    rst_n = 1;
    @(negedge clk);
  endtask

  // drive a request at a falling edge; it is captured at the next rising edge
  task automatic fetch(input logic [63:0] va, input logic [2:0] tl, input logic am,
                       input logic mmuEn, input logic hit, input logic tpriv,
                       input logic priv, input logic [39:0] tpa, input logic [39:0] tmask);
    reqValid = 1; reqVa = va; trapLevel = tl; addrMask = am; mmuEnable = mmuEn;
    tlbHit = hit; tlbPriv = tpriv; privMode = priv; tlbPa = tpa; tlbPageMask = tmask;
    #1;
  endtask

  task automatic settle();
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    doReset();

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      reqValid = 1; reqVa = VECS[i].va; hyperPriv = VECS[i].hp; redState = VECS[i].red;
      trapLevel = VECS[i].tl; privMode = VECS[i].priv; addrMask = VECS[i].am;
      mmuEnable = VECS[i].mmuEn; tlbHit = VECS[i].hit; tlbPriv = VECS[i].tpriv;
      tlbPa = VECS[i].tpa; tlbPageMask = VECS[i].tmask;
      @(negedge clk);
      chk(rspValid == 1, $sformatf("R%0d", VECS[i].req), $sformatf("vec %0d valid", i),
          64'(rspValid), 1);
      chk(rspTrap == VECS[i].expTrap, $sformatf("R%0d", VECS[i].req),
          $sformatf("vec %0d trap", i), 64'(rspTrap), 64'(VECS[i].expTrap));
      chk(rspPa == VECS[i].expPa, $sformatf("R%0d", VECS[i].req),
          $sformatf("vec %0d pa", i), 64'(rspPa), 64'(VECS[i].expPa));
    end

    idle();
    doReset();

    // R1 R6 primary-context virtual lookup, then R7 miss tag and status
    fetch(64'h0000_0012_3456_7AB8, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 40'h0, 40'h1FFF);
    chk(tlbReqValid == 1, "R6", "lookup issued", 64'(tlbReqValid), 1);
    chk(tlbReqCtx == 13'h0AB, "R1", "primary ctx", 64'(tlbReqCtx), 64'h0AB);
    chk(tlbReqReal == 0, "R6", "virtual lookup", 64'(tlbReqReal), 0);
    chk(tlbReqPid == 3'd3, "R6", "partition", 64'(tlbReqPid), 3);
    chk(tlbReqVa == 64'h0000_0012_3456_7AB8, "R6", "lookup va", tlbReqVa, 64'h0000_0012_3456_7AB8);
    settle();
    chk(rspTrap == 3'd4, "R7", "fast miss", 64'(rspTrap), 4);
    chk(tagAccess == 64'h0000_0012_3456_60AB, "R7", "tag access", tagAccess, 64'h0000_0012_3456_60AB);
    chk(faultStatus == 0, "R7", "status unchanged on miss", 64'(faultStatus), 0);

    // R1 nucleus context when trap level nonzero
    fetch(64'h0000_0012_3456_7AB8, 3'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 40'h0, 40'h1FFF);
    chk(tlbReqCtx == 0, "R1", "nucleus ctx", 64'(tlbReqCtx), 0);
    settle();
    chk(rspTrap == 3'd0, "R1", "nucleus hit", 64'(rspTrap), 0);

    // R6 R4 real lookup with mask presents raw VA; miss tag uses masked VA
    fetch(64'hFFFF_0000_0000_4010, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 40'h0, 40'h1FFF);
    chk(tlbReqReal == 1, "R6", "real lookup", 64'(tlbReqReal), 1);
    chk(tlbReqCtx == 0, "R6", "real ctx", 64'(tlbReqCtx), 0);
    chk(tlbReqVa == 64'hFFFF_0000_0000_4010, "R6", "real raw va", tlbReqVa, 64'hFFFF_0000_0000_4010);
    settle();
    chk(rspTrap == 3'd3, "R7", "real miss", 64'(rspTrap), 3);
    chk(tagAccess == 64'h4000, "R7", "tag masked va", tagAccess, 64'h4000);

    // R4 virtual lookup presents masked VA
    fetch(64'hFFFF_0000_0000_4010, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 40'h77_0000_0000, 40'h1FFF);
    chk(tlbReqVa == 64'h4010, "R4", "masked lookup va", tlbReqVa, 64'h4010);
    settle();
    chk(rspPa == 40'h77_0000_0010, "R9", "pa from entry", 64'(rspPa), 64'h77_0000_0010);

    // R10 first fault, primary context
    fetch(64'h1004, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 40'h0, 40'h1FFF);
    settle();
    chk(faultStatus == 24'h800081, "R10", "status first fault", 64'(faultStatus), 64'h800081);

    // R10 second fault sets overflow, nucleus context
    fetch(64'h0000_8000_0000_0000, 3'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 40'h0, 40'h1FFF);
    settle();
    chk(faultStatus == 24'h040123, "R10", "status overflow", 64'(faultStatus), 64'h040123);

    // R2 bypass leaves status and tag untouched, no lookup
    hyperPriv = 1;
    fetch(64'h0000_8000_0000_0003, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 40'h0, 40'h1FFF);
    chk(tlbReqValid == 0, "R2", "no lookup in bypass", 64'(tlbReqValid), 0);
    settle();
    chk(faultStatus == 24'h040123, "R2", "status kept", 64'(faultStatus), 64'h040123);
    chk(tagAccess == 64'h4000, "R2", "tag kept", tagAccess, 64'h4000);

    // R11 no request: no response, status kept
    reqVa = 64'h1001;
    @(negedge clk);
    chk(rspValid == 0, "R11", "idle no response", 64'(rspValid), 0);
    chk(faultStatus == 24'h040123, "R11", "idle status kept", 64'(faultStatus), 64'h040123);

    // R8 privilege violation status
    fetch(64'h2000, 3'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 40'h33_0000_0000, 40'h1FFF);
    settle();
    chk(rspTrap == 3'd2, "R8", "access trap", 64'(rspTrap), 2);
    chk(rspPa == 0, "R11", "pa zero on trap", 64'(rspPa), 0);
    chk(faultStatus == 24'h800183, "R8", "priv status", 64'(faultStatus), 64'h800183);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule